// File: doc/BRIEF.md
# Hopping Local Oscillator and Down-Conversion Mixer

This block produces the local oscillator for one receive channel and mixes incoming samples with it. A 32-bit phase accumulator advances by an active tuning word on every clock. A programmable offset is added to its value, and the top ten bits of that sum address a folded sine table. The sine and cosine values from the table drive a mixer. The mixer handles either a real sample or a complex I/Q pair, and it can be bypassed so that the pair reaches the output untouched.

Software writes the next tuning word at any time. The word takes effect only when a one-cycle hop strobe arrives. At the hop, the accumulator can either restart from zero, which gives a repeatable starting phase, or carry on from where it was, which keeps the phase continuous. For better spur behaviour, an optional pseudo-random dither can be mixed into the low bits of the accumulator.

Top module: `nco_mixer`

## Requirements
- R1: While reset is held, out_valid_o, out_i_o and out_q_o are 0. Reset also clears the accumulator and the active tuning word.
- R2: Each cycle with in_valid_i high gives out_valid_o high exactly two rising edges later, together with that sample's result. In every other cycle out_valid_o is low.
- R3: freq_word_i is copied into the active tuning word only on an edge where hop_i is 1. On any other edge, changes on freq_word_i have no effect on the output.
- R4: The tuning word is a 32-bit two's-complement fraction of a cycle per sample: (carrier mod clock) / clock × 2^32. For example, 0x4000_0000 is a quarter turn per sample. With dither off, the accumulator adds the active word (mod 2^32) on each edge. The sample's phase is accumulator + phase_offset_i, and its top 10 bits form index p. sin(p) = round(32767·sin(2π(p+0.5)/1024)) and cos(p) = sin((p+256) mod 1024), with a tolerance of 1 LSB.
- R5: With is_complex_i = 0, the output is I = x·cos and Q = x·sin, where x = in_a_i and in_b_i is ignored. Each product sum is rounded as (s + 2^14) >>> 15.
- R6: With is_complex_i = 1, the output is I = a·cos − b·sin and Q = a·sin + b·cos, where a = in_a_i and b = in_b_i.
- R7: Mixer results that fall outside the 16-bit range saturate to 32767 or −32768.
- R8: With bypass_i = 1, out_i_o = in_a_i and out_q_o = in_b_i exactly, with the same two-cycle latency. is_complex_i has no effect in this mode.
- R9: If hop_i and clr_on_hop_i are both 1, the accumulator is 0 after that edge and advances by the new word from the next edge on. phase_offset_i still applies.
- R10: If hop_i is 1 and clr_on_hop_i is 0, the hop edge adds the old word. The new word is used from the following edge, so no phase step occurs.
- R11: With dither_en_i = 1, each edge also adds the low 4 bits of a 16-bit LFSR to the accumulator. The LFSR uses polynomial x^16+x^14+x^13+x^11, is seeded with 0xACE1 and steps every cycle. Each step is therefore between the word and the word + 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word_i | input | 32 | Pending tuning word |
| phase_offset_i | input | 32 | Phase offset added after the accumulator |
| hop_i | input | 1 | One-cycle hop strobe |
| clr_on_hop_i | input | 1 | Zero the accumulator on a hop |
| dither_en_i | input | 1 | Add LFSR dither to the accumulator |
| bypass_i | input | 1 | Pass the input pair unchanged |
| is_complex_i | input | 1 | Input is an I/Q pair (0: real on in_a_i) |
| in_valid_i | input | 1 | Input sample valid |
| in_a_i | input | 16 | Real sample or I component |
| in_b_i | input | 16 | Q component |
| out_valid_o | output | 1 | Output sample valid |
| out_i_o | output | 16 | Baseband I |
| out_q_o | output | 16 | Baseband Q |

## Verification
The bench aims at the hop boundary. If the clear flag is ignored, the phase drifts away from the bench's expected trajectory after the hop. A word that is loaded without a strobe changes the output early. Quadrant folding is exercised at 90° steps and at 45°, where the complex products overflow. A mirrored address or a wrong sign shows up as an inverted or swapped I/Q value, and a missing clamp shows up as a wrapped value near ±32768. Dither is checked by parking the phase just below a table bin edge: with dither off the output must stay in that bin, and with dither on it must move into the next bin only.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int PHASE_W  = 32;
  localparam int LUT_AW   = 10;
  localparam int DATA_W   = 16;
  localparam int DITH_W   = 4;
  localparam int LFSR_W   = 16;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS = 16'hB400;
  localparam longint PI_Q30 = 64'sd3373259426;

  // Sine at the centre of quarter-wave bin k, scaled by amp, using an integer Taylor series in Q30
  function automatic int quarter_sine(input int k, input int qn, input int amp);
    longint x, x2, term, sum;
    x    = (longint'(2 * k + 1) * PI_Q30) / (4 * longint'(qn));
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int n = 1; n <= 6; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return int'((sum * longint'(amp) + (longint'(1) <<< 29)) >>> 30);
  endfunction
endpackage

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int PHASE_W = nco_pkg::PHASE_W,
  parameter int DITH_W  = nco_pkg::DITH_W,
  parameter int LFSR_W  = nco_pkg::LFSR_W,
  parameter logic [LFSR_W-1:0] SEED = nco_pkg::LFSR_SEED,
  parameter logic [LFSR_W-1:0] TAPS = nco_pkg::LFSR_TAPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq_word_i,
  input  logic               hop_i,
  input  logic               clr_on_hop_i,
  input  logic               dither_en_i,
  output logic [PHASE_W-1:0] acc_o,
  output logic [PHASE_W-1:0] freq_act_o
);
  logic [LFSR_W-1:0]  lfsr_q;
  logic [PHASE_W-1:0] dith_ext;
  logic               hop_clear;

  assign hop_clear = hop_i & clr_on_hop_i;
  assign dith_ext  = dither_en_i ? PHASE_W'(lfsr_q[DITH_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_o      <= '0;
      freq_act_o <= '0;
    end else begin
      acc_o <= hop_clear ? '0 : acc_o + freq_act_o + dith_ext;
      if (hop_i) freq_act_o <= freq_word_i;
    end
  end
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int LUT_AW = nco_pkg::LUT_AW,
  parameter int DATA_W = nco_pkg::DATA_W
) (
  input  logic [LUT_AW-1:0]        idx_i,
  output logic signed [DATA_W-1:0] sin_o,
  output logic signed [DATA_W-1:0] cos_o
);
  localparam int QN  = 2 ** (LUT_AW - 2);
  localparam int AMP = 2 ** (DATA_W - 1) - 1;

  logic signed [DATA_W-1:0] quarter [QN];
  logic [LUT_AW-1:0]        port_idx [2];
  logic signed [DATA_W-1:0] port_val [2];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam int V = nco_pkg::quarter_sine(k, QN, AMP);
    assign quarter[k] = DATA_W'(V);
  end

  assign port_idx[0] = idx_i;
  assign port_idx[1] = idx_i + LUT_AW'(QN);

  for (genvar j = 0; j < 2; j++) begin : g_port
    logic [1:0]               quad;
    logic [LUT_AW-3:0]        addr;
    logic signed [DATA_W-1:0] mag;
    always_comb begin
      quad        = port_idx[j][LUT_AW-1 -: 2];
      addr        = quad[0] ? ~port_idx[j][LUT_AW-3:0] : port_idx[j][LUT_AW-3:0];
      mag         = quarter[addr];
      port_val[j] = quad[1] ? -mag : mag;
    end
  end

  assign sin_o = port_val[0];
  assign cos_o = port_val[1];
endmodule

// File: rtl/nco_mix.sv
module nco_mix #(
  parameter int DATA_W = nco_pkg::DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_a_i,
  input  logic signed [DATA_W-1:0] in_b_i,
  input  logic                     is_complex_i,
  input  logic                     bypass_i,
  input  logic signed [DATA_W-1:0] sin_i,
  input  logic signed [DATA_W-1:0] cos_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_i_o,
  output logic signed [DATA_W-1:0] out_q_o
);
  localparam int PW = 2 * DATA_W + 1;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DATA_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DATA_W - 1));

  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] t;
    t = (v + (PW'(1) <<< (DATA_W - 2))) >>> (DATA_W - 1);
    if (t > MAXV)      return MAXV[DATA_W-1:0];
    else if (t < MINV) return MINV[DATA_W-1:0];
    return t[DATA_W-1:0];
  endfunction

  logic                     v1, cplx1, byp1;
  logic signed [DATA_W-1:0] a1, b1, s1, c1, bb;
  logic signed [PW-1:0]     mi, mq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; cplx1 <= 1'b0; byp1 <= 1'b0;
      a1 <= '0; b1 <= '0; s1 <= '0; c1 <= '0;
    end else begin
      v1 <= in_valid_i; cplx1 <= is_complex_i; byp1 <= bypass_i;
      a1 <= in_a_i; b1 <= in_b_i; s1 <= sin_i; c1 <= cos_i;
    end
  end

  always_comb begin
    bb = cplx1 ? b1 : '0;
    mi = PW'(a1) * PW'(c1) - PW'(bb) * PW'(s1);
    mq = PW'(a1) * PW'(s1) + PW'(bb) * PW'(c1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0; out_i_o <= '0; out_q_o <= '0;
    end else begin
      out_valid_o <= v1;
      out_i_o     <= byp1 ? a1 : rnd_sat(mi);
      out_q_o     <= byp1 ? b1 : rnd_sat(mq);
    end
  end
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int PHASE_W = nco_pkg::PHASE_W,
  parameter int LUT_AW  = nco_pkg::LUT_AW,
  parameter int DATA_W  = nco_pkg::DATA_W,
  parameter int DITH_W  = nco_pkg::DITH_W,
  parameter int LFSR_W  = nco_pkg::LFSR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PHASE_W-1:0]       freq_word_i,
  input  logic [PHASE_W-1:0]       phase_offset_i,
  input  logic                     hop_i,
  input  logic                     clr_on_hop_i,
  input  logic                     dither_en_i,
  input  logic                     bypass_i,
  input  logic                     is_complex_i,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_a_i,
  input  logic signed [DATA_W-1:0] in_b_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_i_o,
  output logic signed [DATA_W-1:0] out_q_o
);
  logic [PHASE_W-1:0]       acc_q, freq_act_q;
  logic [LUT_AW-1:0]        lut_idx;
  logic signed [DATA_W-1:0] lo_sin, lo_cos;
  logic                     hop_clear;

  assign hop_clear = hop_i & clr_on_hop_i;
  assign lut_idx   = LUT_AW'((acc_q + phase_offset_i) >> (PHASE_W - LUT_AW));

  nco_phase #(.PHASE_W(PHASE_W), .DITH_W(DITH_W), .LFSR_W(LFSR_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .freq_word_i(freq_word_i), .hop_i(hop_i),
    .clr_on_hop_i(clr_on_hop_i), .dither_en_i(dither_en_i),
    .acc_o(acc_q), .freq_act_o(freq_act_q)
  );

  nco_sincos_rom #(.LUT_AW(LUT_AW), .DATA_W(DATA_W)) u_rom (
    .idx_i(lut_idx), .sin_o(lo_sin), .cos_o(lo_cos)
  );

  nco_mix #(.DATA_W(DATA_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_a_i(in_a_i),
    .in_b_i(in_b_i), .is_complex_i(is_complex_i), .bypass_i(bypass_i),
    .sin_i(lo_sin), .cos_i(lo_cos), .out_valid_o(out_valid_o),
    .out_i_o(out_i_o), .out_q_o(out_q_o)
  );
endmodule

// File: rtl/nco_mixer_chk.sv
module nco_mixer_chk #(
  parameter int PHASE_W = nco_pkg::PHASE_W,
  parameter int DATA_W  = nco_pkg::DATA_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     hop_i,
  input logic                     hop_clear,
  input logic                     dither_en_i,
  input logic                     bypass_i,
  input logic                     in_valid_i,
  input logic signed [DATA_W-1:0] in_a_i,
  input logic signed [DATA_W-1:0] in_b_i,
  input logic                     out_valid_o,
  input logic signed [DATA_W-1:0] out_i_o,
  input logic signed [DATA_W-1:0] out_q_o,
  input logic [PHASE_W-1:0]       acc_q,
  input logic [PHASE_W-1:0]       freq_act_q
);
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |-> ##2 out_valid_o);
  p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |-> ##2 !out_valid_o);
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_i |=> $stable(freq_act_q));
  p_plain_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dither_en_i && !hop_clear) |=> acc_q == $past(acc_q) + $past(freq_act_q));
  p_pass_thru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && bypass_i) |-> ##2 (out_i_o == $past(in_a_i, 2) && out_q_o == $past(in_b_i, 2)));
  p_hop_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hop_clear |=> acc_q == '0);
  p_dither_span_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dither_en_i && !hop_clear) |=> (acc_q - $past(acc_q) - $past(freq_act_q)) < PHASE_W'(16));
endmodule

bind nco_mixer nco_mixer_chk #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hop_i(hop_i), .hop_clear(hop_clear),
  .dither_en_i(dither_en_i), .bypass_i(bypass_i), .in_valid_i(in_valid_i),
  .in_a_i(in_a_i), .in_b_i(in_b_i), .out_valid_o(out_valid_o),
  .out_i_o(out_i_o), .out_q_o(out_q_o), .acc_q(acc_q), .freq_act_q(freq_act_q)
);

// File: tb/test_nco_mixer.sv
module test_nco_mixer;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] freq_word = '0, offset = '0;
  logic hop = 1'b0, clr = 1'b0, dith = 1'b0, byp = 1'b0, cplx = 1'b0, vld = 1'b0;
  logic signed [15:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int nchk = 0, nfail = 0;
  logic [31:0] m_acc, m_freq;

  always #(CLK_P/2) clk = ~clk;

  nco_mixer i_nco_mixer (
    .clk(clk), .rst_n(rst_n), .freq_word_i(freq_word), .phase_offset_i(offset),
    .hop_i(hop), .clr_on_hop_i(clr), .dither_en_i(dith), .bypass_i(byp),
    .is_complex_i(cplx), .in_valid_i(vld), .in_a_i(in_a), .in_b_i(in_b),
    .out_valid_o(out_valid), .out_i_o(out_i), .out_q_o(out_q)
  );

  // accumulator model from R3, R4, R9, R10 (dither off)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc <= '0; m_freq <= '0;
    end else begin
      m_acc <= (hop && clr) ? 32'd0 : m_acc + m_freq;
      if (hop) m_freq <= freq_word;
    end
  end

  function automatic int bsin(input int p);
    real th;
    th = 2.0 * 3.14159265358979 * (real'(p % 1024) + 0.5) / 1024.0;
    return int'(32767.0 * $sin(th));
  endfunction

  function automatic int rs(input longint v);
    longint r;
    r = (v + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    nchk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hop = 0; clr = 0; dith = 0; byp = 0; cplx = 0; vld = 0;
    freq_word = '0; offset = '0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hop_to(input logic [31:0] w, input logic c);
    freq_word = w; clr = c; hop = 1'b1;
    @(negedge clk);
    hop = 1'b0; clr = 1'b0;
  endtask

  // one sample: drive, check idle cycle, check result two edges later
  task automatic mix_check(input int a, input int b, input string tag, input int force_p);
    int p, s, c, bb, ei, eq;
    logic [31:0] ph;
    in_a = 16'(a); in_b = 16'(b); vld = 1'b1;
    ph = m_acc + offset;
    p  = (force_p >= 0) ? force_p : int'(ph[31:22]);
    s  = bsin(p); c = bsin(p + 256);
    bb = cplx ? b : 0;
    if (byp) begin ei = a; eq = b; end
    else begin
      ei = rs(longint'(a) * c - longint'(bb) * s);
      eq = rs(longint'(a) * s + longint'(bb) * c);
    end
    @(negedge clk);
    vld = 1'b0;
    check("R2 no valid one cycle after input", int'(out_valid), 0, 0);
    @(negedge clk);
    check("R2 valid two cycles after input", int'(out_valid), 1, 0);
    check({tag, " I"}, int'(out_i), ei, byp ? 0 : 2);
    check({tag, " Q"}, int'(out_q), eq, byp ? 0 : 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vld = 1'b1; in_a = 16'sd1000;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0, 0);
    check("R1 I in reset", int'(out_i), 0, 0);
    check("R1 Q in reset", int'(out_q), 0, 0);
    vld = 1'b0;
  endtask

  task automatic t_bypass();
    do_reset();
    byp = 1'b1; cplx = 1'b1;
    hop_to(32'h1234_0000, 1'b0);
    mix_check(1234, -4321, "R8 bypass", -1);
    mix_check(-32768, 32767, "R8 bypass extremes", -1);
    cplx = 1'b0;
    mix_check(77, -99, "R8 bypass real flag", -1);
  endtask

  task automatic t_real();
    do_reset();
    hop_to(32'h4000_0000, 1'b0);
    for (int k = 0; k < 6; k++) begin
      mix_check(20000 - 3000 * k, 12345 + k, "R5 real quarter-turn", -1);
      @(negedge clk);
    end
  endtask

  task automatic t_complex();
    do_reset();
    cplx = 1'b1;
    offset = 32'h0ABC_0000;
    hop_to(32'h1357_9BDF, 1'b0);
    for (int k = 0; k < 6; k++)
      mix_check(15000 - 7000 * k, -9000 + 4100 * k, "R6 complex", -1);
  endtask

  task automatic t_hold();
    do_reset();
    hop_to(32'h0800_0000, 1'b0);
    mix_check(30000, 0, "R3 after hop", -1);
    freq_word = 32'h6000_0000;
    for (int k = 0; k < 4; k++) mix_check(30000, 0, "R3 word without hop", -1);
  endtask

  task automatic t_hop_clear();
    do_reset();
    offset = 32'h1000_0000;
    hop_to(32'h0F0F_0000, 1'b0);
    repeat (5) @(negedge clk);
    hop_to(32'h2222_2222, 1'b1);
    for (int k = 0; k < 4; k++) mix_check(30000, 0, "R9 clear on hop", -1);
  endtask

  task automatic t_hop_cont();
    do_reset();
    offset = 32'h3000_0000;
    hop_to(32'h0F0F_0000, 1'b0);
    repeat (5) @(negedge clk);
    hop_to(32'h2222_2222, 1'b0);
    for (int k = 0; k < 4; k++) mix_check(30000, 0, "R10 continuous hop", -1);
  endtask

  task automatic t_saturate();
    do_reset();
    cplx = 1'b1;
    offset = 32'h2000_0000;
    mix_check(-32768, -32768, "R7 negative clamp", -1);
    check("R7 Q clamps to -32768", int'(out_q), -32768, 0);
    mix_check(32767, -32768, "R7 positive clamp", -1);
    check("R7 I clamps to 32767", int'(out_i), 32767, 0);
  endtask

  task automatic t_dither();
    do_reset();
    offset = 32'h003F_FFF0;
    repeat (30) @(negedge clk);
    mix_check(32767, 0, "R11 dither off stays in bin 0", 0);
    do_reset();
    offset = 32'h003F_FFF0;
    dith = 1'b1;
    repeat (30) @(negedge clk);
    mix_check(32767, 0, "R11 dither on moves to bin 1", 1);
    dith = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #(CLK_P * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_real();
    t_complex();
    t_hold();
    t_hop_clear();
    t_hop_cont();
    t_saturate();
    t_dither();
    summary();
    $finish;
  end
endmodule